// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control store of a multi-channel DMA engine. A processor writes and reads it over a simple word-addressed bus with a combinational read path. It holds five per-channel attribute vectors: channel enable, request mask, burst-only, alternate descriptor select and high priority. Each vector has one address that sets bits and a second address that clears bits, so software can change one channel without a read-modify-write.

The bank also holds several other registers:
- a sticky per-channel completion vector, cleared by writing 1;
- a routing mask that decides where completions are sent;
- a sticky bus error flag;
- a master enable and a 3-bit protection code;
- the base address of the descriptor table.

A status word reports the channel count and the sequencer state, which arrives on an input. The data mover and the channel arbiter consume the control vectors straight from the output ports.

The number of implemented channels is a parameter from 1 to 32. Every vector port is that wide, and higher bits read back as zero.

Top module: `dma_chan_regbank`

## Requirements
- R1: Writing to a set address (burst-only 0x18, request mask 0x20, channel enable 0x28, alternate select 0x30, high priority 0x38) sets every attribute bit written as 1 and leaves bits written as 0 unchanged. The new value shows on the output vector and on a read of the set address one cycle later.
- R2: Writing to the clear address (set address + 4) clears every attribute bit written as 1 and leaves the others unchanged. Clear addresses read as 0.
- R3: Write-data bits at or above NCH change no state, and those bit positions always read as 0.
- R4: A read of 0x00 returns NCH-1 in bits [20:16], `seq_state_i` in bits [7:4] and the master enable in bit [0]. All other bits read 0.
- R5: Address 0x04 is read/write and holds master enable in bit [0] and the protection code in bits [7:5]. These drive `master_en_o` and `prot_o`, and all other bits read 0.
- R6: Address 0x08 stores bits [31:10] of the descriptor base, and its low bits read 0. Address 0x0C is read-only and returns that base plus 0x200.
- R7: A 1 on `done_set_i[c]` sets done bit c, which then stays set until software writes 1 to bit c of 0x504. Writing 0 has no effect. When a set and a clear reach the same bit in the same cycle, the set wins.
- R8: Address 0x520 is a plain read/write mask. `periph_done_o` = done AND NOT mask, and `done_any_o` = OR of (done AND mask).
- R9: `bus_err_i` sets an error flag that reads back in bit [0] of 0x4C. Writing 1 to that bit clears it, and a set in the same cycle wins.
- R10: A write to 0x14 drives the written bits on `sw_req_o` for exactly the next cycle. At all other times `sw_req_o` is 0, and 0x14 reads 0.
- R11: After reset, every stored register and every output is 0.
- R12: A read of 0x10 returns `wait_req_i`.
- R13: Writes to unlisted addresses change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_wr_i | input | 1 | write strobe |
| bus_addr_i | input | ADDR_W | byte address; bits [1:0] ignored |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | combinational read data for bus_addr_i |
| seq_state_i | input | 4 | sequencer state for status readback |
| wait_req_i | input | NCH | wait-on-request status for readback |
| done_set_i | input | NCH | per-channel completion pulses |
| bus_err_i | input | 1 | bus error pulse |
| master_en_o | output | 1 | master enable |
| prot_o | output | 3 | protection code |
| desc_base_o | output | 32 | descriptor table base (low 10 bits 0) |
| sw_req_o | output | NCH | one-cycle software request pulses |
| burst_only_o | output | NCH | burst-only attribute |
| req_mask_o | output | NCH | request mask attribute |
| chan_en_o | output | NCH | channel enable attribute |
| alt_sel_o | output | NCH | alternate descriptor select |
| hi_prio_o | output | NCH | high priority attribute |
| done_o | output | NCH | sticky done vector |
| done_mask_o | output | NCH | done routing mask |
| periph_done_o | output | NCH | done bits routed to peripherals |
| done_any_o | output | 1 | combined done of masked-in channels |

## Verification
A set/clear register that writes to the wrong vector, or that uses the wrong polarity, shows up on the affected output port in the cycle after the write. It also shows on the next read of the set address. A lost done bit or error bit stays wrong until a write-1 clear, so it is visible on every later read of 0x504 or 0x4C and on the routing outputs. Collisions between a hardware set and a software clear in the same cycle are driven on purpose, so a clear-wins fault shows immediately. Ignored writes are judged by reading back every register after them.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
    localparam int unsigned OFF_STATUS   = 32'h000;
    localparam int unsigned OFF_CFG      = 32'h004;
    localparam int unsigned OFF_BASE     = 32'h008;
    localparam int unsigned OFF_ALTBASE  = 32'h00C;
    localparam int unsigned OFF_WAITREQ  = 32'h010;
    localparam int unsigned OFF_SWREQ    = 32'h014;
    localparam int unsigned OFF_ATTR0    = 32'h018;
    localparam int unsigned ATTR_STRIDE  = 8;
    localparam int unsigned N_ATTR       = 5;
    localparam int unsigned OFF_ERR      = 32'h04C;
    localparam int unsigned OFF_DONE     = 32'h504;
    localparam int unsigned OFF_DONEMASK = 32'h520;
    localparam int unsigned ALT_OFFSET   = 32'h200;
    localparam int unsigned BASE_LSB     = 10;

    // attribute index: 0 burst-only, 1 request mask, 2 enable, 3 alternate, 4 priority
    function automatic int unsigned attr_set_off(input int unsigned idx);
        return OFF_ATTR0 + ATTR_STRIDE * idx;
    endfunction

    function automatic int unsigned attr_clr_off(input int unsigned idx);
        return OFF_ATTR0 + ATTR_STRIDE * idx + 4;
    endfunction
endpackage

// File: rtl/dma_setclr_vec.sv
module dma_setclr_vec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] vec_o
);
    typedef struct packed {
        logic [W-1:0] vec;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_we_i) st_d.vec = st_q.vec | wdata_i;
        if (clr_we_i) st_d.vec = st_q.vec & ~wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_o = st_q.vec;
endmodule

// File: rtl/dma_done_track.sv
module dma_done_track #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] done_set_i,
    input  logic         clr_we_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] done_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] periph_done_o,
    output logic         done_any_o
);
    typedef struct packed {
        logic [W-1:0] done;
        logic [W-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i)  st_d.done = st_q.done & ~wdata_i;
        // hardware completion overrides a simultaneous software clear
        st_d.done = st_d.done | done_set_i;
        if (mask_we_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o        = st_q.done;
    assign mask_o        = st_q.mask;
    assign periph_done_o = st_q.done & ~st_q.mask;
    assign done_any_o    = |(st_q.done & st_q.mask);
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
    import dma_rb_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [3:0]        seq_state_i,
    input  logic [NCH-1:0]    wait_req_i,
    input  logic [NCH-1:0]    done_set_i,
    input  logic              bus_err_i,
    output logic              master_en_o,
    output logic [2:0]        prot_o,
    output logic [31:0]       desc_base_o,
    output logic [NCH-1:0]    sw_req_o,
    output logic [NCH-1:0]    burst_only_o,
    output logic [NCH-1:0]    req_mask_o,
    output logic [NCH-1:0]    chan_en_o,
    output logic [NCH-1:0]    alt_sel_o,
    output logic [NCH-1:0]    hi_prio_o,
    output logic [NCH-1:0]    done_o,
    output logic [NCH-1:0]    done_mask_o,
    output logic [NCH-1:0]    periph_done_o,
    output logic              done_any_o
);
    localparam int BASE_W = 32 - BASE_LSB;
    localparam logic [4:0] CNT_FIELD = 5'(NCH - 1);

    typedef struct packed {
        logic              master_en;
        logic [2:0]        prot;
        logic [BASE_W-1:0] base;
        logic              err;
        logic [NCH-1:0]    swreq;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [ADDR_W-1:0] wa;
    logic [NCH-1:0]    wd_ch;
    logic [NCH-1:0]    attr_vec [N_ATTR];
    logic              unused_addr_lsb;

    assign wa              = {bus_addr_i[ADDR_W-1:2], 2'b00};
    assign wd_ch           = bus_wdata_i[NCH-1:0];
    assign unused_addr_lsb = ^bus_addr_i[1:0];

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
        return a == ADDR_W'(off);
    endfunction

    // one set/clear vector per channel attribute
    for (genvar g = 0; g < N_ATTR; g++) begin : g_attr
        dma_setclr_vec #(.W(NCH)) u_vec (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_we_i (bus_wr_i && hit(wa, attr_set_off(g))),
            .clr_we_i (bus_wr_i && hit(wa, attr_clr_off(g))),
            .wdata_i  (wd_ch),
            .vec_o    (attr_vec[g])
        );
    end

    assign burst_only_o = attr_vec[0];
    assign req_mask_o   = attr_vec[1];
    assign chan_en_o    = attr_vec[2];
    assign alt_sel_o    = attr_vec[3];
    assign hi_prio_o    = attr_vec[4];

    dma_done_track #(.W(NCH)) u_done (
        .clk           (clk),
        .rst_n         (rst_n),
        .done_set_i    (done_set_i),
        .clr_we_i      (bus_wr_i && hit(wa, OFF_DONE)),
        .mask_we_i     (bus_wr_i && hit(wa, OFF_DONEMASK)),
        .wdata_i       (wd_ch),
        .done_o        (done_o),
        .mask_o        (done_mask_o),
        .periph_done_o (periph_done_o),
        .done_any_o    (done_any_o)
    );

    always_comb begin
        cfg_d       = cfg_q;
        cfg_d.swreq = '0;
        if (bus_wr_i && hit(wa, OFF_CFG)) begin
            cfg_d.master_en = bus_wdata_i[0];
            cfg_d.prot      = bus_wdata_i[7:5];
        end
        if (bus_wr_i && hit(wa, OFF_BASE)) cfg_d.base = bus_wdata_i[31:BASE_LSB];
        if (bus_wr_i && hit(wa, OFF_SWREQ)) cfg_d.swreq = wd_ch;
        if (bus_wr_i && hit(wa, OFF_ERR) && bus_wdata_i[0]) cfg_d.err = 1'b0;
        if (bus_err_i) cfg_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign master_en_o = cfg_q.master_en;
    assign prot_o      = cfg_q.prot;
    assign desc_base_o = {cfg_q.base, {BASE_LSB{1'b0}}};
    assign sw_req_o    = cfg_q.swreq;

    always_comb begin
        bus_rdata_o = '0;
        if (hit(wa, OFF_STATUS))
            bus_rdata_o = {11'b0, CNT_FIELD, 8'b0, seq_state_i, 3'b0, cfg_q.master_en};
        if (hit(wa, OFF_CFG))      bus_rdata_o = {24'b0, cfg_q.prot, 4'b0, cfg_q.master_en};
        if (hit(wa, OFF_BASE))     bus_rdata_o = desc_base_o;
        if (hit(wa, OFF_ALTBASE))  bus_rdata_o = desc_base_o + ALT_OFFSET;
        if (hit(wa, OFF_WAITREQ))  bus_rdata_o = 32'(wait_req_i);
        if (hit(wa, OFF_ERR))      bus_rdata_o = {31'b0, cfg_q.err};
        if (hit(wa, OFF_DONE))     bus_rdata_o = 32'(done_o);
        if (hit(wa, OFF_DONEMASK)) bus_rdata_o = 32'(done_mask_o);
        for (int i = 0; i < N_ATTR; i++)
            if (hit(wa, attr_set_off(i))) bus_rdata_o = 32'(attr_vec[i]);
    end
endmodule

// File: rtl/dma_rb_checker.sv
module dma_rb_checker
    import dma_rb_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [31:0]       bus_wdata_i,
    input logic [NCH-1:0]    done_set_i,
    input logic [NCH-1:0]    chan_en_o,
    input logic [NCH-1:0]    done_o,
    input logic [NCH-1:0]    sw_req_o
);
    logic [ADDR_W-1:0] wa;
    logic [NCH-1:0]    wd;
    assign wa = {bus_addr_i[ADDR_W-1:2], 2'b00};
    assign wd = bus_wdata_i[NCH-1:0];

    assert_set_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && wa == ADDR_W'(attr_set_off(2)))
        |=> ((chan_en_o & $past(wd)) == $past(wd)));

    assert_clr_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && wa == ADDR_W'(attr_clr_off(2)))
        |=> ((chan_en_o & $past(wd)) == '0));

    assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_set_i != '0) |=> ((done_o & $past(done_set_i)) == $past(done_set_i)));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && wa == ADDR_W'(OFF_DONE))
        |=> ((done_o & $past(done_o)) == $past(done_o)));

    assert_swreq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req_o != '0) |-> $past(bus_wr_i && wa == ADDR_W'(OFF_SWREQ)));
endmodule

bind dma_chan_regbank dma_rb_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .done_set_i  (done_set_i),
    .chan_en_o   (chan_en_o),
    .done_o      (done_o),
    .sw_req_o    (sw_req_o)
);

// File: tb/sim_dma_chan_regbank.sv
`timescale 1ns/1ps
module sim_dma_chan_regbank;
    localparam int NCH = 20;
    localparam logic [31:0] IMPL = (32'h1 << NCH) - 1;

    logic clk = 0, rst_n = 0;
    logic bus_wr = 0, bus_err = 0, done_any;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, rdata, desc_base;
    logic [3:0] seq_state = '0;
    logic [2:0] prot;
    logic master_en;
    logic [NCH-1:0] wait_req = '0, done_set = '0, sw_req, burst_only, req_mask,
                    chan_en, alt_sel, hi_prio, done_v, done_mask, periph_done;

    always #5 clk = ~clk;

    dma_chan_regbank #(.NCH(NCH), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata), .seq_state_i(seq_state),
        .wait_req_i(wait_req), .done_set_i(done_set), .bus_err_i(bus_err),
        .master_en_o(master_en), .prot_o(prot), .desc_base_o(desc_base),
        .sw_req_o(sw_req), .burst_only_o(burst_only), .req_mask_o(req_mask),
        .chan_en_o(chan_en), .alt_sel_o(alt_sel), .hi_prio_o(hi_prio),
        .done_o(done_v), .done_mask_o(done_mask), .periph_done_o(periph_done),
        .done_any_o(done_any)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] m_attr [5];
    logic [31:0] m_done = 0, m_mask = 0, m_cfg = 0, m_base = 0;
    logic m_err = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] r = 0;
        for (int i = 0; i < 5; i++) if (a == 12'(24 + 8*i)) r = m_attr[i];
        case (a)
            12'h000: r = (32'(NCH - 1) << 16) | (32'(seq_state) << 4) | {31'b0, m_cfg[0]};
            12'h004: r = m_cfg;
            12'h008: r = m_base;
            12'h00C: r = m_base + 32'h200;
            12'h010: r = 32'(wait_req);
            12'h04C: r = {31'b0, m_err};
            12'h504: r = m_done;
            12'h520: r = m_mask;
            default: ;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (a == 12'h000) return "R4 status";
        if (a == 12'h004) return "R5 config";
        if (a == 12'h008 || a == 12'h00C) return "R6 base";
        if (a == 12'h010) return "R12 waitreq";
        if (a == 12'h014) return "R10 swreq read";
        if (a >= 12'h018 && a <= 12'h03C) return a[2] ? "R2 clear-addr read" : "R1 attr read";
        if (a == 12'h04C) return "R9 error";
        if (a == 12'h504) return "R7 done";
        if (a == 12'h520) return "R8 mask";
        return "R13 unused";
    endfunction

    task automatic read_chk(input logic [11:0] a);
        @(negedge clk);
        bus_wr = 0; bus_addr = a;
        #1;
        check(tag_of(a), rdata, exp_read(a));
    endtask

    task automatic read_all();
        logic [11:0] lst [20] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
            12'h018, 12'h01C, 12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034,
            12'h038, 12'h03C, 12'h040, 12'h04C, 12'h504, 12'h520};
        for (int i = 0; i < 20; i++) read_chk(lst[i]);
    endtask

    task automatic check_outs();
        check("R1 burst_only_o", 32'(burst_only), m_attr[0]);
        check("R1 req_mask_o",   32'(req_mask),   m_attr[1]);
        check("R1 chan_en_o",    32'(chan_en),    m_attr[2]);
        check("R1 alt_sel_o",    32'(alt_sel),    m_attr[3]);
        check("R1 hi_prio_o",    32'(hi_prio),    m_attr[4]);
        check("R7 done_o",       32'(done_v),     m_done);
        check("R8 periph_done_o", 32'(periph_done), m_done & ~m_mask);
        check("R8 done_any_o",   {31'b0, done_any}, {31'b0, |(m_done & m_mask)});
        check("R5 master/prot",  {28'b0, prot, master_en}, {28'b0, m_cfg[7:5], m_cfg[0]});
        check("R6 desc_base_o",  desc_base, m_base);
    endtask

    task automatic step(input logic [11:0] a, input logic [31:0] d, input logic we,
                        input logic [NCH-1:0] dset, input logic eset);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = we; done_set = dset; bus_err = eset;
        @(negedge clk);
        bus_wr = 0; done_set = '0; bus_err = 0;
        if (we) begin
            for (int i = 0; i < 5; i++) begin
                if (a == 12'(24 + 8*i)) m_attr[i] = m_attr[i] | (d & IMPL);
                if (a == 12'(28 + 8*i)) m_attr[i] = m_attr[i] & ~(d & IMPL);
            end
            case (a)
                12'h004: m_cfg = d & 32'h0000_00E1;
                12'h008: m_base = d & 32'hFFFF_FC00;
                12'h04C: if (d[0]) m_err = 0;
                12'h504: m_done = m_done & ~(d & IMPL);
                12'h520: m_mask = d & IMPL;
                default: ;
            endcase
        end
        m_done = m_done | 32'(dset);
        if (eset) m_err = 1;
        check("R10 sw_req_o", 32'(sw_req), (we && a == 12'h014) ? (d & IMPL) : 32'h0);
        check_outs();
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] wl [19] = '{12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
            12'h018, 12'h01C, 12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034,
            12'h038, 12'h03C, 12'h040, 12'h04C, 12'h504, 12'h520};
        void'($urandom(32'd4242));
        for (int i = 0; i < 5; i++) m_attr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: reset state
        check_outs();
        check("R11 sw_req_o reset", 32'(sw_req), 0);
        read_all();
        // R3: all-ones set reaches only implemented channels
        step(12'h028, 32'hFFFF_FFFF, 1, '0, 0);
        read_chk(12'h028);
        // R1: writing zeros to a set address changes nothing
        step(12'h028, 32'h0, 1, '0, 0);
        // R2: clear a pattern
        step(12'h02C, 32'h0000_A5A5, 1, '0, 0);
        read_chk(12'h028);
        // R7: set and clear of the same done bit in one cycle, set wins
        step(12'h504, 32'h0, 1, NCH'(32'h0000_0011), 0);
        step(12'h504, 32'h0000_0011, 1, NCH'(32'h0000_0001), 0);
        read_chk(12'h504);
        // R9: error collision, set wins; then clear
        step(12'h04C, 32'h1, 1, '0, 1);
        read_chk(12'h04C);
        step(12'h04C, 32'h1, 1, '0, 0);
        read_chk(12'h04C);
        // R13: unused address write
        step(12'h040, 32'hFFFF_FFFF, 1, '0, 0);
        read_all();
        // R10: software request pulse
        step(12'h014, 32'hFFF0_0F0F, 1, '0, 0);
        step(12'h000, 32'h0, 0, '0, 0);
        // R6 / R5 directed
        step(12'h008, 32'h1234_5678, 1, '0, 0);
        step(12'h004, 32'hFFFF_FFFF, 1, '0, 0);
        read_all();
        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] d;
            seq_state = 4'($urandom);
            wait_req  = NCH'($urandom);
            d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            step(wl[$urandom % 19], d, 1'($urandom % 8 != 0),
                 NCH'($urandom & $urandom & $urandom), 1'($urandom % 16 == 0));
            if (n % 8 == 0) read_all();
        end
        read_all();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule